// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Client

This block lets local logic put bytes into, and get bytes out of, circular buffers that are kept in the memory of another processor. It has no path to that memory except a byte-wide read/write port into a memory cycle engine. Before it touches that port it raises a bus ownership request and waits for the grant. It drops the request once the access sequence is over.

Each channel has a descriptor with a base address, a size mask and local copies of the input and output indices. A three-byte header sits just below the base address. The data bytes start at the base address itself. The client owns one index of each ring: the output index for rings it drains and the input index for rings it fills. On every check it reads only the partner's index from shared memory.

A command carries an opcode, a channel number, a base address and a data byte. The block answers with a one-cycle done pulse and a set of result flags. No command ever blocks on the ring's fill level. An empty ring yields a no-data flag, and a full ring rejects the put.

Top module: `ring_client`

## Requirements
- R1: The init command (cmd_op=0) with a nonzero base stores the base. Inside one ownership window it then reads base-3 into the mask, base-2 into the local input index and base-1 into the local output index, in that order.
- R2: A channel whose base is zero makes no bus request and no memory access. Such a channel includes any channel not initialized since reset. A get (cmd_op=1) on it returns rsp_nodata=1, a put (cmd_op=2) returns rsp_reject=1, and a status query (cmd_op=3) returns rsp_empty=1 and rsp_full=0.
- R3: A ring is empty when the input index read from base-2 equals the local output index. A get on an empty ring returns rsp_nodata=1 after that single read and writes nothing. A status query reports rsp_empty from the same comparison.
- R4: A ring is full when (local input index + 1) AND mask equals the output index read from base-1. A put on a full ring returns rsp_reject=1 after that single read and writes nothing. A status query reports rsp_full from the same comparison.
- R5: A get on a non-empty ring reads the byte at base + output index and returns it on rsp_rdata with rsp_nodata=0. It then sets the output index to (index+1) AND mask and writes the new value to base-1.
- R6: A put on a non-full ring writes cmd_wdata to base + input index. It then sets the input index to (index+1) AND mask and writes the new value to base-2.
- R7: Every memory access happens while bus_own is high and bus_gnt has been seen. Each command that uses the bus raises bus_own exactly once, and bus_own is low again in the cycle rsp_done pulses.
- R8: Each channel keeps its own base, mask and indices, selected by cmd_chan. Commands on one channel leave the others unchanged.
- R9: A memory request holds mem_addr, mem_we and mem_wdata steady until mem_ack.
- R10: After reset the block is idle: cmd_ready=1, bus_own=0, mem_req=0, rsp_done=0, and every channel has base zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when cmd_ready is high |
| cmd_op | input | 2 | 0 init, 1 get, 2 put, 3 status |
| cmd_chan | input | CW | Channel number |
| cmd_base | input | AW | Base address (init only) |
| cmd_wdata | input | DW | Byte to put |
| cmd_ready | output | 1 | Block idle, command may be given |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Byte returned by get |
| rsp_nodata | output | 1 | Get found the ring empty |
| rsp_reject | output | 1 | Put found the ring full |
| rsp_empty | output | 1 | Status or get: ring empty |
| rsp_full | output | 1 | Status or put: ring full |
| bus_own | output | 1 | Bus ownership request, held for the access sequence |
| bus_gnt | input | 1 | Ownership granted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write byte |
| mem_rdata | input | DW | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
A corrupted local index does not show up right away. It shows at the next get or put on that channel: the byte comes from the wrong slot, or the wrong value lands in the header index byte, so a check after each command catches it. A wrong mask shows only when an index wraps, so the sweeps run each ring several times around its length. They also mix partner activity so that empty and full are each reached from both directions. A channel select fault shows as a second channel's header or data being touched, and the trace of accessed addresses and the ownership count catch this on the command that causes it.

// File: rtl/ring_client.sv
module ring_client #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [CW-1:0] cmd_chan,
  input  logic [AW-1:0] cmd_base,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_nodata,
  output logic          rsp_reject,
  output logic          rsp_empty,
  output logic          rsp_full,
  output logic          bus_own,
  input  logic          bus_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam logic [1:0] OP_INIT = 2'd0;
  localparam logic [1:0] OP_GET  = 2'd1;
  localparam logic [1:0] OP_PUT  = 2'd2;
  localparam logic [1:0] OP_STAT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_ACC, S_DONE} st_t;

  st_t           st;
  logic [1:0]    op_q, step_q;
  logic [CW-1:0] ch_q;
  logic [DW-1:0] wd_q;

  logic [AW-1:0] base_q [NCH];
  logic [DW-1:0] mask_q [NCH];
  logic [DW-1:0] in_q   [NCH];
  logic [DW-1:0] out_q  [NCH];

  logic [AW-1:0] cb;
  logic [DW-1:0] cm, ci, co, nxt_in, nxt_out;

  assign cb      = base_q[ch_q];
  assign cm      = mask_q[ch_q];
  assign ci      = in_q[ch_q];
  assign co      = out_q[ch_q];
  assign nxt_in  = (ci + 1'b1) & cm;
  assign nxt_out = (co + 1'b1) & cm;

  assign cmd_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_DONE);
  assign bus_own   = (st == S_ACQ) || (st == S_ACC);
  assign mem_req   = (st == S_ACC);

  always_comb begin
    mem_addr  = cb - AW'(3);
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (op_q)
      OP_INIT: mem_addr = cb - AW'(3) + AW'(step_q);
      OP_GET: begin
        case (step_q)
          2'd0: mem_addr = cb - AW'(2);
          2'd1: mem_addr = cb + AW'(co);
          default: begin
            mem_addr  = cb - AW'(1);
            mem_we    = 1'b1;
            mem_wdata = nxt_out;
          end
        endcase
      end
      OP_PUT: begin
        case (step_q)
          2'd0: mem_addr = cb - AW'(1);
          2'd1: begin
            mem_addr  = cb + AW'(ci);
            mem_we    = 1'b1;
            mem_wdata = wd_q;
          end
          default: begin
            mem_addr  = cb - AW'(2);
            mem_we    = 1'b1;
            mem_wdata = nxt_in;
          end
        endcase
      end
      default: mem_addr = (step_q == 2'd0) ? cb - AW'(2) : cb - AW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= OP_INIT;
      step_q     <= '0;
      ch_q       <= '0;
      wd_q       <= '0;
      rsp_rdata  <= '0;
      rsp_nodata <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_empty  <= 1'b0;
      rsp_full   <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        in_q[i]   <= '0;
        out_q[i]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q       <= cmd_op;
          ch_q       <= cmd_chan;
          wd_q       <= cmd_wdata;
          step_q     <= '0;
          rsp_rdata  <= '0;
          rsp_nodata <= 1'b0;
          rsp_reject <= 1'b0;
          rsp_empty  <= 1'b0;
          rsp_full   <= 1'b0;
          if (cmd_op == OP_INIT) begin
            base_q[cmd_chan] <= cmd_base;
            if (cmd_base == '0) begin
              mask_q[cmd_chan] <= '0;
              in_q[cmd_chan]   <= '0;
              out_q[cmd_chan]  <= '0;
              st               <= S_DONE;
            end else begin
              st <= S_ACQ;
            end
          end else if (base_q[cmd_chan] == '0) begin
            rsp_nodata <= (cmd_op == OP_GET);
            rsp_reject <= (cmd_op == OP_PUT);
            rsp_empty  <= 1'b1;
            st         <= S_DONE;
          end else begin
            st <= S_ACQ;
          end
        end
        S_ACQ: if (bus_gnt) st <= S_ACC;
        S_ACC: if (mem_ack) begin
          step_q <= step_q + 2'd1;
          case (op_q)
            OP_INIT: begin
              case (step_q)
                2'd0: mask_q[ch_q] <= mem_rdata;
                2'd1: in_q[ch_q]   <= mem_rdata;
                default: begin
                  out_q[ch_q] <= mem_rdata;
                  st          <= S_DONE;
                end
              endcase
            end
            OP_GET: begin
              case (step_q)
                2'd0: if (mem_rdata == co) begin
                  rsp_nodata <= 1'b1;
                  rsp_empty  <= 1'b1;
                  st         <= S_DONE;
                end
                2'd1: rsp_rdata <= mem_rdata;
                default: begin
                  out_q[ch_q] <= nxt_out;
                  st          <= S_DONE;
                end
              endcase
            end
            OP_PUT: begin
              case (step_q)
                2'd0: if (mem_rdata == nxt_in) begin
                  rsp_reject <= 1'b1;
                  rsp_full   <= 1'b1;
                  st         <= S_DONE;
                end
                2'd1: ;
                default: begin
                  in_q[ch_q] <= nxt_in;
                  st         <= S_DONE;
                end
              endcase
            end
            default: begin
              if (step_q == 2'd0) begin
                rsp_empty <= (mem_rdata == co);
              end else begin
                rsp_full <= (mem_rdata == nxt_in);
                st       <= S_DONE;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ring_client_chk.sv
module ring_client_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_done,
  input logic          rsp_nodata,
  input logic          rsp_reject,
  input logic          bus_own,
  input logic          bus_gnt,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);

  // R7
  access_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_own && bus_gnt);

  // R7
  release_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !bus_own);

  // R7
  own_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_own) |-> rsp_done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !(rsp_nodata && rsp_reject));

endmodule

bind ring_client ring_client_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_ring_client.sv
`timescale 1ns/1ps
module sim_ring_client;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [1:0]  cmd_chan = 2'd0;
  logic [15:0] cmd_base = 16'd0;
  logic [7:0]  cmd_wdata = 8'd0;
  logic        cmd_ready, rsp_done, rsp_nodata, rsp_reject, rsp_empty, rsp_full;
  logic [7:0]  rsp_rdata;
  logic        bus_own, mem_req, mem_we;
  logic        bus_gnt = 1'b0;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #10 clk = ~clk;

  ring_client u0 (.*);

  logic [7:0]  mem [1024];
  logic        part_we = 1'b0;
  logic [9:0]  part_addr = '0;
  logic [7:0]  part_data = '0;
  int own_rise = 0, viol = 0, unstab = 0, trc = 0, gcnt = 0, dly = 0;
  logic own_prev = 1'b0, pend = 1'b0, w0 = 1'b0;
  logic [15:0] a0 = '0;
  logic [15:0] tr_a [16];
  logic        tr_w [16];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'd0;
      mem_ack = 1'b0;
      bus_gnt = 1'b0;
      pend = 1'b0;
      gcnt = 0;
    end else begin
      if (part_we) mem[part_addr] = part_data;
      if (bus_own && !own_prev) own_rise++;
      own_prev = bus_own;
      if (mem_req && !bus_gnt) viol++;
      if (!bus_own) begin
        bus_gnt = 1'b0;
        gcnt = 0;
      end else if (!bus_gnt) begin
        if (gcnt >= 1) bus_gnt = 1'b1;
        else gcnt++;
      end
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (!pend) begin
          pend = 1'b1;
          a0 = mem_addr;
          w0 = mem_we;
          dly = trc % 3;
        end
        if (dly == 0) begin
          if (mem_addr != a0 || mem_we != w0) unstab++;
          if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:0]];
          tr_a[trc % 16] = mem_addr;
          tr_w[trc % 16] = mem_we;
          trc++;
          pend = 1'b0;
          mem_ack = 1'b1;
        end else dly--;
      end
    end
  end

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic [7:0] r_data;
  logic r_nodata, r_reject, r_empty, r_full, r_own;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic partner_wr(input logic [15:0] a, input logic [7:0] d);
    part_addr = a[9:0];
    part_data = d;
    part_we = 1'b1;
    @(negedge clk);
    #1 part_we = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input int ch, input logic [15:0] base, input logic [7:0] d);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch[1:0]; cmd_base = base; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!rsp_done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_done, "R7 command completes", n, 0);
    r_data = rsp_rdata; r_nodata = rsp_nodata; r_reject = rsp_reject;
    r_empty = rsp_empty; r_full = rsp_full; r_own = bus_own;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tin, tout, rin, rout, t0, o0;
    logic full_e;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(cmd_ready && !bus_own && !mem_req && !rsp_done, "R10 idle after reset",
        {cmd_ready, bus_own, mem_req, rsp_done}, 4'b1000);

    // R2 channel never initialized
    t0 = trc; o0 = own_rise;
    do_cmd(2'd2, 3, 16'h0, 8'h55);
    chk(r_reject, "R2 put on uninit channel", r_reject, 1);
    chk(trc == t0 && own_rise == o0, "R2 no bus on uninit", trc - t0, 0);

    partner_wr(16'h0FD, 8'd3);
    partner_wr(16'h1FD, 8'd7);
    partner_wr(16'h1FE, 8'd5);
    partner_wr(16'h1FF, 8'd5);

    // R1 init header reads
    t0 = trc; o0 = own_rise;
    do_cmd(2'd0, 0, 16'h0100, 8'h0);
    chk(trc == t0 + 3, "R1 init access count", trc - t0, 3);
    for (int k = 0; k < 3; k++)
      chk(tr_a[(t0 + k) % 16] == 16'h00FD + k && !tr_w[(t0 + k) % 16], "R1 header read order",
          tr_a[(t0 + k) % 16], 16'h00FD + k);
    chk(own_rise == o0 + 1 && !r_own, "R7 one window per init", own_rise - o0, 1);
    do_cmd(2'd0, 1, 16'h0200, 8'h0);

    // R3 empty after init
    do_cmd(2'd3, 0, 16'h0, 8'h0);
    chk(r_empty && !r_full, "R3 R4 status of fresh ring", {r_empty, r_full}, 2'b10);
    t0 = trc;
    do_cmd(2'd1, 0, 16'h0, 8'h0);
    chk(r_nodata && trc == t0 + 1, "R3 get empty single read", trc - t0, 1);

    // R6 R4 put sweep on channel 0
    tin = 0; tout = 0;
    for (int i = 0; i < 28; i++) begin
      d = 8'(i * 7 + 3);
      full_e = (((tin + 1) & 3) == tout);
      t0 = trc;
      do_cmd(2'd2, 0, 16'h0, d);
      chk(r_reject == full_e, "R4 put reject matches full", r_reject, full_e);
      if (full_e) begin
        chk(trc == t0 + 1, "R4 no write when full", trc - t0, 1);
      end else begin
        chk(mem[10'h100 + tin] == d, "R6 data at base+in", mem[10'h100 + tin], d);
        tin = (tin + 1) & 3;
        chk(mem[10'h0FE] == 8'(tin), "R6 input index written", mem[10'h0FE], tin);
      end
      if (i % 4 == 3) begin
        tout = tin;
        partner_wr(16'h00FF, 8'(tout));
      end else if (i % 7 == 5 && tout != tin) begin
        tout = (tout + 1) & 3;
        partner_wr(16'h00FF, 8'(tout));
      end
      do_cmd(2'd3, 0, 16'h0, 8'h0);
      chk(r_full == (((tin + 1) & 3) == tout) && r_empty == (tin == 0),
          "R3 R4 status sweep", {r_empty, r_full}, {tin == 0, ((tin + 1) & 3) == tout});
    end

    // R5 R3 get sweep on channel 1
    rin = 5; rout = 5;
    for (int i = 0; i < 24; i++) begin
      for (int k = 0; k < i % 4; k++) begin
        if (((rin + 1) & 7) != rout) begin
          partner_wr(16'h0200 + 16'(rin), 8'(i * 16 + k + 1));
          rin = (rin + 1) & 7;
        end
      end
      partner_wr(16'h01FE, 8'(rin));
      for (int g = 0; g < 2; g++) begin
        o0 = own_rise;
        do_cmd(2'd1, 1, 16'h0, 8'h0);
        chk(r_nodata == (rin == rout), "R3 get nodata when empty", r_nodata, rin == rout);
        chk(own_rise == o0 + 1 && !r_own, "R7 released before done", own_rise - o0, 1);
        if (rin != rout) begin
          chk(r_data == mem[10'h200 + rout], "R5 get byte", r_data, mem[10'h200 + rout]);
          rout = (rout + 1) & 7;
          chk(mem[10'h1FF] == 8'(rout), "R5 output index written", mem[10'h1FF], rout);
        end
      end
    end

    // R8 channel 0 unaffected by channel 1 traffic
    do_cmd(2'd3, 0, 16'h0, 8'h0);
    chk(r_full == (((tin + 1) & 3) == tout), "R8 channel 0 state kept", r_full, ((tin + 1) & 3) == tout);
    chk(mem[10'h0FE] == 8'(tin) && mem[10'h0FF] == 8'(tout), "R8 channel 0 header untouched",
        mem[10'h0FE], tin);

    // R2 zero base channel
    t0 = trc; o0 = own_rise;
    do_cmd(2'd0, 2, 16'h0, 8'h0);
    do_cmd(2'd3, 2, 16'h0, 8'h0);
    chk(r_empty && !r_full, "R2 zero base status", {r_empty, r_full}, 2'b10);
    do_cmd(2'd1, 2, 16'h0, 8'h0);
    chk(r_nodata, "R2 zero base get", r_nodata, 1);
    do_cmd(2'd2, 2, 16'h0, 8'h77);
    chk(r_reject, "R2 zero base put", r_reject, 1);
    chk(trc == t0 && own_rise == o0, "R2 zero base no bus", trc - t0, 0);

    chk(viol == 0, "R7 access without grant", viol, 0);
    chk(unstab == 0, "R9 request held stable", unstab, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule